// File: doc/BRIEF.md
# Third-Order Digital Voltage-Loop Compensator

This block closes the voltage loop of a buck converter in logic. Each time the sample strobe fires (typically at 10 kHz), it forms the error between a reference word and a 12-bit ADC reading of the scaled output voltage. At full scale the ADC reads 4096 counts for 5 V, and the feedback divider scales the output by 0.12, so a 5 V to 10 V output reference maps to about 492 to 983 counts.

The error passes through a third-order recursive difference equation. Four numerator terms weight the present error and the three errors before it. Three feedback terms weight the three previous outputs. All coefficients are integers held on input ports and scaled by 2^7 relative to the leading denominator term. The feedback coefficients arrive with their signs already flipped, so every product is added.

The sum is shifted right arithmetically by 7 bits and clamped to 0..2000, the span of the PWM sawtooth counter. The clamped value becomes the new compare word and is also the value stored in the output history. A single multiplier is shared over seven cycles per sample. A reload strobe wipes the filter memory whenever new coefficients are applied.

Top module: `vloop_comp`

## Requirements
- R1: After reset, `duty_cmp` is 0 and `done` is 0.
- R2: On an accepted strobe, the new error is `ref_word - adc_word`, taken as a signed two's-complement value one bit wider than the ADC word.
- R3: The new output is floor(S / 128). S = a0·e[n] + a1·e[n-1] + a2·e[n-2] + a3·e[n-3] + b1·u[n-1] + b2·u[n-2] + b3·u[n-3]. Every coefficient is a signed 16-bit port value.
- R4: The output is clamped to the range 0..2000, and the clamped value is what enters the output history.
- R5: `done` is a one-cycle pulse that rises at the 7th rising edge after the edge that accepted the strobe. `duty_cmp` takes its new value on that same edge and changes at no other time except R7.
- R6: A strobe that arrives while a computation is running is ignored, together with the ADC value that comes with it.
- R7: A `coef_load` pulse has three effects on the next edge: it clears all error and output history, it cancels any running computation, and it forces `duty_cmp` to 0.
- R8: Histories shift by one per completed sample. An error applied at sample n reaches the a3 term at sample n+3, and an output produced at sample n reaches the b3 term at sample n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Starts one control update when idle |
| coef_load | input | 1 | Clears filter memory and output |
| adc_word | input | 12 | Measured scaled output voltage, unsigned counts |
| ref_word | input | 12 | Reference, unsigned counts |
| coef_a0 | input | 16 | Signed weight of present error |
| coef_a1 | input | 16 | Signed weight of error one sample back |
| coef_a2 | input | 16 | Signed weight of error two samples back |
| coef_a3 | input | 16 | Signed weight of error three samples back |
| coef_b1 | input | 16 | Signed, pre-negated weight of previous output |
| coef_b2 | input | 16 | Signed, pre-negated weight of output two back |
| coef_b3 | input | 16 | Signed, pre-negated weight of output three back |
| duty_cmp | output | 11 | Compare value for the PWM sawtooth |
| done | output | 1 | One-cycle pulse when `duty_cmp` updates |

## Verification
The assertions assume that the coefficient ports hold still while a computation runs. They also assume that the coefficient and operand ranges keep the 32-bit sum from wrapping. The stimulus therefore changes coefficients only together with a `coef_load` pulse while the block is idle, and keeps every magnitude small enough that the widest sum stays far below 2^31. The strobe is raised during a running computation only on purpose, to check R6.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
    // filter order and number of product terms per sample
    localparam int ORDER = 3;
    localparam int TAPS  = 2 * ORDER + 1;
endpackage

// File: rtl/vloop_hist.sv
module vloop_hist
    import vloop_pkg::*;
#(
    parameter int OPD_W = 13,
    parameter int CMP_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    capture_i,
    input  logic signed [OPD_W-1:0] err_i,
    input  logic                    commit_i,
    input  logic [CMP_W-1:0]        y_i,
    output logic signed [OPD_W-1:0] opd_o [TAPS]
);
    localparam int PAD_W = OPD_W - CMP_W;

    typedef struct packed {
        logic [ORDER:0][OPD_W-1:0]   e;
        logic [ORDER-1:0][CMP_W-1:0] u;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (clear_i) begin
            hist_d = '0;
        end else begin
            if (capture_i) begin
                hist_d.e[0] = err_i;
            end
            if (commit_i) begin
                for (int k = ORDER; k >= 1; k--) begin
                    hist_d.e[k] = hist_q.e[k-1];
                end
                hist_d.u[0] = y_i;
                for (int k = ORDER - 1; k >= 1; k--) begin
                    hist_d.u[k] = hist_q.u[k-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    generate
        for (genvar k = 0; k <= ORDER; k++) begin : g_err_opd
            assign opd_o[k] = $signed(hist_q.e[k]);
        end
        for (genvar j = 0; j < ORDER; j++) begin : g_out_opd
            assign opd_o[ORDER+1+j] = $signed({{PAD_W{1'b0}}, hist_q.u[j]});
        end
    endgenerate
endmodule

// File: rtl/vloop_mac.sv
module vloop_mac
    import vloop_pkg::*;
#(
    parameter int OPD_W  = 13,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     start_i,
    input  logic signed [OPD_W-1:0]  opd_i  [TAPS],
    input  logic signed [COEF_W-1:0] coef_i [TAPS],
    output logic                     busy_o,
    output logic                     fin_o,
    output logic signed [ACC_W-1:0]  sum_o
);
    localparam int STEP_W = $clog2(TAPS);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(TAPS - 1);

    typedef struct packed {
        logic                    busy;
        logic [STEP_W-1:0]       step;
        logic signed [ACC_W-1:0] acc;
    } mac_t;

    mac_t mac_d, mac_q;
    logic signed [ACC_W-1:0] prod;

    always_comb begin
        prod  = ACC_W'(opd_i[mac_q.step]) * ACC_W'(coef_i[mac_q.step]);
        sum_o = mac_q.acc + prod;
        fin_o = mac_q.busy && (mac_q.step == LAST);
        mac_d = mac_q;
        if (clear_i) begin
            mac_d = '0;
        end else if (!mac_q.busy) begin
            if (start_i) begin
                mac_d.busy = 1'b1;
                mac_d.step = '0;
                mac_d.acc  = '0;
            end
        end else begin
            mac_d.acc = sum_o;
            if (fin_o) begin
                mac_d.busy = 1'b0;
                mac_d.step = '0;
            end else begin
                mac_d.step = mac_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mac_q <= '0;
        else        mac_q <= mac_d;
    end

    assign busy_o = mac_q.busy;

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mac_q.busy |-> (mac_q.step <= LAST));
    assert_fin_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);
endmodule

// File: rtl/vloop_out.sv
module vloop_out #(
    parameter int ACC_W   = 32,
    parameter int CMP_W   = 11,
    parameter int SHIFT   = 7,
    parameter int CMP_MAX = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    fin_i,
    input  logic signed [ACC_W-1:0] sum_i,
    output logic [CMP_W-1:0]        y_o,
    output logic [CMP_W-1:0]        duty_o,
    output logic                    done_o
);
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'(CMP_MAX);

    typedef struct packed {
        logic [CMP_W-1:0] duty;
        logic             done;
    } out_t;

    out_t out_d, out_q;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        scaled = sum_i >>> SHIFT;
        if (scaled < 0)        y_o = '0;
        else if (scaled > LIM) y_o = CMP_W'(CMP_MAX);
        else                   y_o = CMP_W'(scaled);

        out_d      = out_q;
        out_d.done = 1'b0;
        if (clear_i) begin
            out_d.duty = '0;
        end else if (fin_i) begin
            out_d.duty = y_o;
            out_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign duty_o = out_q.duty;
    assign done_o = out_q.done;

    assert_duty_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_o <= CMP_W'(CMP_MAX));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/vloop_comp.sv
module vloop_comp
    import vloop_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int COEF_W  = 16,
    parameter int SHIFT   = 7,
    parameter int CMP_MAX = 2000,
    localparam int CMP_W  = $clog2(CMP_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     coef_load,
    input  logic [ADC_W-1:0]         adc_word,
    input  logic [ADC_W-1:0]         ref_word,
    input  logic signed [COEF_W-1:0] coef_a0,
    input  logic signed [COEF_W-1:0] coef_a1,
    input  logic signed [COEF_W-1:0] coef_a2,
    input  logic signed [COEF_W-1:0] coef_a3,
    input  logic signed [COEF_W-1:0] coef_b1,
    input  logic signed [COEF_W-1:0] coef_b2,
    input  logic signed [COEF_W-1:0] coef_b3,
    output logic [CMP_W-1:0]         duty_cmp,
    output logic                     done
);
    localparam int OPD_W = ADC_W + 1;
    localparam int ACC_W = COEF_W + OPD_W + $clog2(TAPS);

    logic signed [OPD_W-1:0]  err;
    logic signed [OPD_W-1:0]  opd  [TAPS];
    logic signed [COEF_W-1:0] coef [TAPS];
    logic                     busy, fin, start;
    logic signed [ACC_W-1:0]  sum;
    logic [CMP_W-1:0]         y_sat;

    assign coef[0] = coef_a0;
    assign coef[1] = coef_a1;
    assign coef[2] = coef_a2;
    assign coef[3] = coef_a3;
    assign coef[4] = coef_b1;
    assign coef[5] = coef_b2;
    assign coef[6] = coef_b3;

    always_comb begin
        err   = $signed(OPD_W'(ref_word)) - $signed(OPD_W'(adc_word));
        start = sample_stb && !busy && !coef_load;
    end

    vloop_hist #(.OPD_W(OPD_W), .CMP_W(CMP_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clear_i(coef_load),
        .capture_i(start), .err_i(err),
        .commit_i(fin), .y_i(y_sat), .opd_o(opd)
    );

    vloop_mac #(.OPD_W(OPD_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear_i(coef_load), .start_i(start),
        .opd_i(opd), .coef_i(coef),
        .busy_o(busy), .fin_o(fin), .sum_o(sum)
    );

    vloop_out #(.ACC_W(ACC_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .CMP_MAX(CMP_MAX)) u_out (
        .clk(clk), .rst_n(rst_n), .clear_i(coef_load),
        .fin_i(fin), .sum_i(sum),
        .y_o(y_sat), .duty_o(duty_cmp), .done_o(done)
    );

    assert_err_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !busy && !coef_load) |=> (opd[0] == $past(err)));
    assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && busy && !coef_load) |=> $stable(opd[0]));
    assert_duty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_load |=> (done || $stable(duty_cmp)));
    assert_load_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        coef_load |=> (duty_cmp == '0 && !done && !busy && opd[1] == '0));
endmodule

// File: tb/vloop_comp_bench.sv
module vloop_comp_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic coef_load = 1'b0;
    logic [11:0] adc_word = '0;
    logic [11:0] ref_word = '0;
    logic signed [15:0] ca0 = '0, ca1 = '0, ca2 = '0, ca3 = '0;
    logic signed [15:0] cb1 = '0, cb2 = '0, cb3 = '0;
    logic [10:0] duty_cmp;
    logic done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural model state
    int me [0:3];
    int mu [1:3];
    int cm [0:6];
    int cur = 0;

    always #10 clk = ~clk;

    vloop_comp u_vloop_comp (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .coef_load(coef_load),
        .adc_word(adc_word), .ref_word(ref_word),
        .coef_a0(ca0), .coef_a1(ca1), .coef_a2(ca2), .coef_a3(ca3),
        .coef_b1(cb1), .coef_b2(cb2), .coef_b3(cb3),
        .duty_cmp(duty_cmp), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) me[k] = 0;
        for (int k = 1; k < 4; k++) mu[k] = 0;
        cur = 0;
    endtask

    // R7: reload coefficients, clears memory and output
    task automatic load(input int a0, input int a1, input int a2, input int a3,
                        input int b1, input int b2, input int b3);
        ca0 = 16'(a0); ca1 = 16'(a1); ca2 = 16'(a2); ca3 = 16'(a3);
        cb1 = 16'(b1); cb2 = 16'(b2); cb3 = 16'(b3);
        cm[0] = a0; cm[1] = a1; cm[2] = a2; cm[3] = a3;
        cm[4] = b1; cm[5] = b2; cm[6] = b3;
        coef_load = 1'b1;
        @(negedge clk);
        coef_load = 1'b0;
        model_clear();
        chk(duty_cmp == 11'd0, "R7 duty after load", int'(duty_cmp), 0);
        chk(done == 1'b0, "R7 done after load", int'(done), 0);
    endtask

    // one control update; poke raises a strobe mid-computation (R6)
    task automatic sample(input int adc, input int rf, input bit poke, input string req);
        int acc, y;
        adc_word = 12'(adc);
        ref_word = 12'(rf);
        sample_stb = 1'b1;
        me[0] = rf - adc;
        acc = 0;
        for (int k = 0; k < 4; k++) acc += cm[k] * me[k];
        for (int k = 1; k < 4; k++) acc += cm[k+3] * mu[k];
        y = acc >>> 7;
        if (y < 0) y = 0;
        if (y > 2000) y = 2000;
        me[3] = me[2]; me[2] = me[1]; me[1] = me[0];
        mu[3] = mu[2]; mu[2] = mu[1]; mu[1] = y;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            if (i > 0) @(negedge clk);
            chk(done == 1'b0, {req, " R5 done low while busy"}, int'(done), 0);
            chk(int'(duty_cmp) == cur, {req, " R5 duty holds"}, int'(duty_cmp), cur);
            if (poke && i == 2) begin
                sample_stb = 1'b1;
                adc_word = 12'(adc ^ 'h3FF);
            end else begin
                sample_stb = 1'b0;
            end
        end
        @(negedge clk);
        chk(done == 1'b1, {req, " R5 done pulse"}, int'(done), 1);
        chk(int'(duty_cmp) == y, req, int'(duty_cmp), y);
        cur = y;
        @(negedge clk);
        chk(done == 1'b0, {req, " R5 done one cycle"}, int'(done), 0);
        chk(int'(duty_cmp) == cur, {req, " R5 duty kept"}, int'(duty_cmp), cur);
    endtask

    initial begin
        model_clear();
        for (int k = 0; k < 7; k++) cm[k] = 0;
        repeat (3) @(negedge clk);
        chk(duty_cmp == 11'd0, "R1 duty in reset", int'(duty_cmp), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(duty_cmp == 11'd0, "R1 duty after reset", int'(duty_cmp), 0);

        // proportional only
        load(128, 0, 0, 0, 0, 0, 0);
        sample(600, 1000, 1'b0, "R2 R3 positive error");
        sample(1500, 1000, 1'b0, "R2 R4 negative error clamps to 0");
        sample(0, 4095, 1'b0, "R4 clamp to 2000");
        sample(700, 900, 1'b1, "R6 strobe during busy ignored");

        // integrator: anti-windup through stored clamped value
        load(64, 0, 0, 0, 128, 0, 0);
        sample(1000, 1200, 1'b0, "R3 integrator step 1");
        sample(1000, 1200, 1'b0, "R3 integrator step 2");
        sample(0, 4095, 1'b0, "R4 integrator saturates");
        sample(0, 4095, 1'b0, "R4 integrator held at 2000");
        sample(2000, 1000, 1'b0, "R4 history holds clamped value");

        // third error tap alone (also proves R7 cleared the history)
        load(0, 0, 0, 128, 0, 0, 0);
        sample(0, 10, 1'b0, "R8 e3 sample 1");
        sample(0, 20, 1'b0, "R8 e3 sample 2");
        sample(0, 30, 1'b0, "R8 e3 sample 3");
        sample(0, 40, 1'b0, "R8 e3 reaches a3");

        // third output tap
        load(128, 0, 0, 0, 0, 0, 128);
        for (int s = 0; s < 5; s++) sample(100, 105, 1'b0, "R8 u3 feedback");

        // mixed signed coefficients
        load(300, -200, 50, -20, 100, -30, 10);
        sample(500, 900, 1'b0, "R3 mixed 1");
        sample(800, 900, 1'b0, "R3 mixed 2");
        sample(950, 900, 1'b0, "R3 mixed 3");
        sample(300, 983, 1'b0, "R3 mixed 4");
        sample(492, 983, 1'b1, "R3 R6 mixed 5");
        sample(983, 492, 1'b0, "R3 mixed 6");

        // reload in the middle of live history
        load(128, 128, 0, 0, 0, 0, 0);
        sample(0, 50, 1'b0, "R7 fresh history after reload");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule